// File: doc/BRIEF.md
# Staged Graphics Power-Gating Sequencer

This controller lowers the power of a graphics engine in steps and brings it back on demand. It tracks two power sub-domains, the 3D pipe and the compute array. Once the 3D pipe goes idle, the engine first gates its clocks while staying powered. If it is still quiet after a programmable hold-off delay, the sequencer saves register state and ramps the affected clocks down. Only then does it open the power switches for the domains it is shutting off. Each handshake step waits for an acknowledge from the hardware that carries it out: the clock ramp logic, the register save/restore engine or the power switches.

There are three domain states: all on; 3D off with compute on; and all off. All-on goes to all-off in one move, ramping all clocks together, when the compute array is also idle when the hold-off expires. If compute is busy, only the 3D pipe is gated; the compute array follows later with its own ramp-down once it goes idle. Wake-up closes the switches first, then ramps the clocks back up, then restores register state. Wake-up is caused by register-bus activity, by 3D activity, or by compute activity while compute is off.

States and transitions:
- ON: entered from reset or from RESTORE. Goes to CG when the 3D pipe is idle and there is no bus wake.
- CG: clocks gated while powered. Goes back to ON on a wake. Goes to SAVE when the hold-off expires, choosing the target (all off, or 3D off only).
- SAVE: goes to RAMP_DN on the save acknowledge.
- RAMP_DN: goes to PWR_DN on the ramp acknowledge.
- PWR_DN: goes to GATED on the switch acknowledge.
- GATED: goes to PWR_UP on a wake. When only compute is still on and it goes idle, goes to RAMP_DN to shut it off.
- PWR_UP, RAMP_UP and RESTORE: each advances on its acknowledge; RESTORE leads back to ON.

Top module: `gfx_pg_sequencer`

## Requirements
- R1: After reset: status state field is ON (0), domain field is 2'b11, error bit and entry count are 0; `pwr_en` is 2'b11; `cg_en` and all request outputs are 0.
- R2: In ON, with `idle_3d` high and `bus_wake` low, the block enters CG (`cg_en`=1, `pwr_en` still 2'b11). It stays in CG for exactly `holdoff`+1 cycles and then moves to SAVE.
- R3: A `bus_wake` pulse or `idle_3d` low during CG returns the block to ON on the next edge with `cg_en` low. `save_req` is never asserted on this path.
- R4: Registers are saved before any clock ramp. `ramp_dn_req` rises only after the save acknowledge, and no `pwr_en` bit falls before the ramp-down acknowledge.
- R5: Bit 0 of `ramp_sel` and `pwr_en` is the 3D pipe and bit 1 is the compute array; a `pwr_en` bit of 1 means that domain is powered. If `idle_cmp` is high when the hold-off expires, the ramp-down uses `ramp_sel`=2'b11 and gating ends with `pwr_en`=2'b00. Otherwise it uses 2'b01 and ends with 2'b10.
- R6: In GATED with only compute powered, `idle_cmp` high and no wake source, the compute clocks ramp down (`ramp_sel`=2'b10). The compute switch then opens, giving `pwr_en`=2'b00.
- R7: In GATED, `bus_wake`, `idle_3d` low, or `idle_cmp` low while compute is off starts a wake. `pwr_en` goes to 2'b11 in PWR_UP before any `ramp_up_req`. The ramp-up then selects exactly the domains that were off, and `restore_req` follows before ON is reached.
- R8: Each of SAVE, RAMP_DN, PWR_DN, PWR_UP, RAMP_UP and RESTORE holds its request and its state until the matching acknowledge arrives. At most one of `save_req`, `restore_req`, `ramp_dn_req` and `ramp_up_req` is high at any time.
- R9: `ack_err` rises after ACK_TIMEOUT cycles spent waiting in one acknowledge state. It stays high until reset, even after the sequence resumes.
- R10: The entry count increases by one on each power-switch opening (PWR_DN acknowledged) and wraps modulo 2^CNT_W.
- R11: `status` holds state code [3:0], domain power mask [5:4], error bit [6] and entry count [CNT_W+6:7]. The state codes are ON=0, CG=1, SAVE=2, RAMP_DN=3, PWR_DN=4, GATED=5, PWR_UP=6, RAMP_UP=7 and RESTORE=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_3d | input | 1 | 3D pipe is idle |
| idle_cmp | input | 1 | Compute array is idle |
| bus_wake | input | 1 | Register-bus access wants the engine awake |
| holdoff | input | DLY_W | Hold-off cycles spent in CG before gating |
| ramp_ack | input | 1 | Clock ramp done |
| save_ack | input | 1 | Register save done |
| restore_ack | input | 1 | Register restore done |
| pwr_ack | input | 1 | Power switches settled |
| ramp_dn_req | output | 1 | Request clock ramp-down of `ramp_sel` domains |
| ramp_up_req | output | 1 | Request clock ramp-up of `ramp_sel` domains |
| ramp_sel | output | 2 | Domains to ramp (bit0 3D, bit1 compute) |
| cg_en | output | 1 | Clock gating enable |
| save_req | output | 1 | Register save request |
| restore_req | output | 1 | Register restore request |
| pwr_en | output | 2 | Power switch enables (1 = powered) |
| ack_err | output | 1 | Sticky acknowledge timeout flag |
| status | output | CNT_W+7 | State, domain mask, error, entry count |

## Verification
The hardest situation to reach from the ports is the second-stage compute shutdown. The block must first gate only the 3D pipe, which needs compute to be busy at the instant the hold-off expires. Compute must then go idle while no wake source is present. The bench holds `idle_cmp` low through the hold-off, confirms the 3D-off mask, then raises `idle_cmp` and follows the compute ramp and switch opening. It then wakes the block by compute activity alone. The timeout is reached by muting the bench's acknowledge responder during SAVE.

// File: rtl/gpg_pkg.sv
package gpg_pkg;

    typedef enum logic [3:0] {
        S_ON      = 4'd0,
        S_CG      = 4'd1,
        S_SAVE    = 4'd2,
        S_RAMP_DN = 4'd3,
        S_PWR_DN  = 4'd4,
        S_GATED   = 4'd5,
        S_PWR_UP  = 4'd6,
        S_RAMP_UP = 4'd7,
        S_RESTORE = 4'd8
    } gpg_state_e;

    // domain power masks: bit0 = 3D pipe, bit1 = compute array
    localparam logic [1:0] MASK_ALL_ON  = 2'b11;
    localparam logic [1:0] MASK_CMP_ON  = 2'b10;
    localparam logic [1:0] MASK_ALL_OFF = 2'b00;

endpackage

// File: rtl/gpg_holdoff_timer.sv
module gpg_holdoff_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DLY_W-1:0] limit,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    assign done = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/gpg_ack_watchdog.sv
module gpg_ack_watchdog #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    input  logic advance,
    output logic err
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT);

    logic [TW-1:0] cnt_q;
    logic          err_q;

    assign err = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (!waiting || advance)
                cnt_q <= '0;
            else if (cnt_q != LIMIT)
                cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LIMIT)
                err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/gfx_pg_sequencer.sv
module gfx_pg_sequencer
    import gpg_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int CNT_W       = 8,
    parameter int ACK_TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle_3d,
    input  logic               idle_cmp,
    input  logic               bus_wake,
    input  logic [DLY_W-1:0]   holdoff,
    input  logic               ramp_ack,
    input  logic               save_ack,
    input  logic               restore_ack,
    input  logic               pwr_ack,
    output logic               ramp_dn_req,
    output logic               ramp_up_req,
    output logic [1:0]         ramp_sel,
    output logic               cg_en,
    output logic               save_req,
    output logic               restore_req,
    output logic [1:0]         pwr_en,
    output logic               ack_err,
    output logic [CNT_W+6:0]   status
);
    gpg_state_e       state_q, state_d;
    logic [1:0]       dom_q, dom_d;
    logic [1:0]       tgt_q, tgt_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hold_done;
    logic             waiting, advance, wake;

    gpg_holdoff_timer #(.DLY_W(DLY_W)) u_holdoff (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == S_CG),
        .limit (holdoff),
        .done  (hold_done)
    );

    gpg_ack_watchdog #(.TIMEOUT(ACK_TIMEOUT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (waiting),
        .advance (advance),
        .err     (ack_err)
    );

    assign wake = bus_wake || !idle_3d || (!dom_q[1] && !idle_cmp);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ON;
            dom_q   <= MASK_ALL_ON;
            tgt_q   <= MASK_ALL_ON;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            dom_q   <= dom_d;
            tgt_q   <= tgt_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        dom_d   = dom_q;
        tgt_d   = tgt_q;
        cnt_d   = cnt_q;
        waiting = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            S_ON: begin
                if (idle_3d && !bus_wake)
                    state_d = S_CG;
            end
            S_CG: begin
                if (bus_wake || !idle_3d) begin
                    state_d = S_ON;
                end else if (hold_done) begin
                    state_d = S_SAVE;
                    tgt_d   = idle_cmp ? MASK_ALL_OFF : MASK_CMP_ON;
                end
            end
            S_SAVE: begin
                waiting = 1'b1;
                advance = save_ack;
                if (save_ack) state_d = S_RAMP_DN;
            end
            S_RAMP_DN: begin
                waiting = 1'b1;
                advance = ramp_ack;
                if (ramp_ack) state_d = S_PWR_DN;
            end
            S_PWR_DN: begin
                waiting = 1'b1;
                advance = pwr_ack;
                if (pwr_ack) begin
                    state_d = S_GATED;
                    dom_d   = tgt_q;
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            S_GATED: begin
                if (wake) begin
                    state_d = S_PWR_UP;
                end else if (dom_q == MASK_CMP_ON && idle_cmp) begin
                    state_d = S_RAMP_DN;
                    tgt_d   = MASK_ALL_OFF;
                end
            end
            S_PWR_UP: begin
                waiting = 1'b1;
                advance = pwr_ack;
                if (pwr_ack) state_d = S_RAMP_UP;
            end
            S_RAMP_UP: begin
                waiting = 1'b1;
                advance = ramp_ack;
                if (ramp_ack) begin
                    state_d = S_RESTORE;
                    dom_d   = MASK_ALL_ON;
                end
            end
            S_RESTORE: begin
                waiting = 1'b1;
                advance = restore_ack;
                if (restore_ack) begin
                    state_d = S_ON;
                    tgt_d   = MASK_ALL_ON;
                end
            end
            default: state_d = S_ON;
        endcase
    end

    // outputs
    always_comb begin
        ramp_dn_req = 1'b0;
        ramp_up_req = 1'b0;
        ramp_sel    = 2'b00;
        cg_en       = 1'b0;
        save_req    = 1'b0;
        restore_req = 1'b0;
        pwr_en      = dom_q;
        unique case (state_q)
            S_ON:      ;
            S_CG:      cg_en = 1'b1;
            S_SAVE:    save_req = 1'b1;
            S_RAMP_DN: begin
                ramp_dn_req = 1'b1;
                ramp_sel    = dom_q & ~tgt_q;
            end
            S_PWR_DN:  pwr_en = tgt_q;
            S_GATED:   cg_en = 1'b1;
            S_PWR_UP:  pwr_en = MASK_ALL_ON;
            S_RAMP_UP: begin
                pwr_en      = MASK_ALL_ON;
                ramp_up_req = 1'b1;
                ramp_sel    = ~dom_q;
            end
            S_RESTORE: begin
                pwr_en      = MASK_ALL_ON;
                restore_req = 1'b1;
            end
            default:   ;
        endcase
    end

    assign status = {cnt_q, ack_err, dom_q, state_q};

endmodule

// File: rtl/gpg_seq_checker.sv
module gpg_seq_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W+6:0] status,
    input logic [1:0]       pwr_en,
    input logic             save_req,
    input logic             save_ack,
    input logic             restore_req,
    input logic             restore_ack,
    input logic             ramp_dn_req,
    input logic             ramp_up_req,
    input logic             ramp_ack,
    input logic             pwr_ack,
    input logic             ack_err
);
    logic [3:0]       st;
    logic [CNT_W-1:0] ecnt;

    assign st   = status[3:0];
    assign ecnt = status[CNT_W+6:7];

    // R2
    save_after_cg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_req) |-> $past(st) == 4'd1);

    // R4
    pwr_off_after_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pwr_en) & ~pwr_en)) |-> $past(ramp_dn_req && ramp_ack));

    // R7
    pwr_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pwr_en & ~$past(pwr_en))) |-> st == 4'd6);

    // R8
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_ack) |=> save_req);

    // R8
    restore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !restore_ack) |=> restore_req);

    // R8
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ramp_dn_req || ramp_up_req) && !ramp_ack) |=> $stable(st));

    // R8
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, restore_req, ramp_dn_req, ramp_up_req}));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_err) |-> ack_err);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ecnt != $past(ecnt)) |-> ($past(pwr_ack) && $past(st) == 4'd4));

endmodule

bind gfx_pg_sequencer gpg_seq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status      (status),
    .pwr_en      (pwr_en),
    .save_req    (save_req),
    .save_ack    (save_ack),
    .restore_req (restore_req),
    .restore_ack (restore_ack),
    .ramp_dn_req (ramp_dn_req),
    .ramp_up_req (ramp_up_req),
    .ramp_ack    (ramp_ack),
    .pwr_ack     (pwr_ack),
    .ack_err     (ack_err)
);

// File: tb/tb_gfx_pg_sequencer.sv
module tb_gfx_pg_sequencer;
    localparam int CLK_PERIOD  = 10;
    localparam int DLY_W       = 8;
    localparam int CNT_W       = 8;
    localparam int ACK_TIMEOUT = 64;

    localparam logic [3:0] ST_ON = 4'd0, ST_CG = 4'd1, ST_SAVE = 4'd2, ST_RDN = 4'd3,
                           ST_GATED = 4'd5, ST_PUP = 4'd6, ST_RUP = 4'd7,
                           ST_RST = 4'd8;

    // vector: {holdoff[12:5], idle_cmp[4], exp ramp_sel[3:2], exp gated mask[1:0]}
    localparam logic [12:0] VEC [4] = '{
        {8'd0,  1'b1, 2'b11, 2'b00},
        {8'd3,  1'b0, 2'b01, 2'b10},
        {8'd7,  1'b1, 2'b11, 2'b00},
        {8'd12, 1'b0, 2'b01, 2'b10}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic idle_3d = 1'b0, idle_cmp = 1'b0, bus_wake = 1'b0;
    logic [DLY_W-1:0] holdoff = '0;
    logic ramp_ack = 1'b0, save_ack = 1'b0, restore_ack = 1'b0, pwr_ack = 1'b0;
    logic ramp_dn_req, ramp_up_req, cg_en, save_req, restore_req, ack_err;
    logic [1:0] ramp_sel, pwr_en;
    logic [CNT_W+6:0] status;

    int n_chk = 0, n_fail = 0;
    bit ack_en = 1'b1;
    bit saw_save = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gfx_pg_sequencer #(.DLY_W(DLY_W), .CNT_W(CNT_W), .ACK_TIMEOUT(ACK_TIMEOUT)) dut (
        .clk(clk), .rst_n(rst_n), .idle_3d(idle_3d), .idle_cmp(idle_cmp),
        .bus_wake(bus_wake), .holdoff(holdoff), .ramp_ack(ramp_ack),
        .save_ack(save_ack), .restore_ack(restore_ack), .pwr_ack(pwr_ack),
        .ramp_dn_req(ramp_dn_req), .ramp_up_req(ramp_up_req), .ramp_sel(ramp_sel),
        .cg_en(cg_en), .save_req(save_req), .restore_req(restore_req),
        .pwr_en(pwr_en), .ack_err(ack_err), .status(status)
    );

    // acknowledge responder: one-cycle pulses on the falling edge
    logic pwr_wait;
    assign pwr_wait = (status[3:0] == 4'd4) || (status[3:0] == ST_PUP);

    always @(negedge clk) begin
        ramp_ack    <= ack_en && (ramp_dn_req || ramp_up_req) && !ramp_ack;
        save_ack    <= ack_en && save_req && !save_ack;
        restore_ack <= ack_en && restore_req && !restore_ack;
        pwr_ack     <= ack_en && pwr_wait && !pwr_ack;
    end

    always @(posedge clk) if (save_req) saw_save <= 1'b1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_st(input string req, input logic [3:0] code, input int maxc);
        for (int i = 0; i < maxc && status[3:0] !== code; i++) @(negedge clk);
        check(req, {28'd0, status[3:0]}, {28'd0, code});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_3d = 1'b0; idle_cmp = 1'b0; bus_wake = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] c0;
        do_reset();
        // R1 / R11 reset values
        check("R1 status", {17'd0, status}, 32'h30);
        check("R1 pwr_en", {30'd0, pwr_en}, 32'd3);
        check("R1 requests", {27'd0, cg_en, save_req, restore_req, ramp_dn_req, ramp_up_req}, 32'd0);
        check("R11 domain field", {30'd0, status[5:4]}, 32'd3);

        // table walk: R2 R4 R5 R7 R10
        for (int i = 0; i < 4; i++) begin
            int n;
            logic [1:0] xsel, xdom;
            c0 = status[CNT_W+6:7];
            holdoff  = VEC[i][12:5];
            idle_cmp = VEC[i][4];
            xsel     = VEC[i][3:2];
            xdom     = VEC[i][1:0];
            idle_3d  = 1'b1;
            @(negedge clk);
            check("R2 enter CG", {28'd0, status[3:0]}, {28'd0, ST_CG});
            check("R2 cg_en powered", {29'd0, cg_en, pwr_en}, 32'd7);
            n = 0;
            while (status[3:0] == ST_CG && n < 300) begin n++; @(negedge clk); end
            check("R2 hold-off length", n, {24'd0, VEC[i][12:5]} + 1);
            check("R4 save first", {31'd0, save_req}, 32'd1);
            wait_st("R4 reach ramp", ST_RDN, 10);
            check("R5 ramp_sel down", {30'd0, ramp_sel}, {30'd0, xsel});
            check("R4 switches closed during ramp", {30'd0, pwr_en}, 32'd3);
            wait_st("R5 reach gated", ST_GATED, 10);
            check("R5 gated mask", {30'd0, pwr_en}, {30'd0, xdom});
            check("R10 count step", {24'd0, status[CNT_W+6:7]}, {24'd0, c0 + 8'd1});
            if (i % 2 == 0) bus_wake = 1'b1; else idle_3d = 1'b0;
            @(negedge clk);
            bus_wake = 1'b0;
            idle_3d  = 1'b0;
            check("R7 switches first", {28'd0, status[3:0]}, {28'd0, ST_PUP});
            check("R7 pwr_en on, no ramp", {29'd0, pwr_en, ramp_up_req}, 32'd6);
            wait_st("R7 reach ramp up", ST_RUP, 10);
            check("R7 ramp_sel up", {30'd0, ramp_sel}, {30'd0, ~xdom});
            wait_st("R7 restore", ST_RST, 10);
            check("R7 restore_req", {31'd0, restore_req}, 32'd1);
            wait_st("R7 back on", ST_ON, 10);
            check("R7 domain on", {30'd0, status[5:4]}, 32'd3);
        end

        // R3 cancel by bus wake
        holdoff = 8'd20; idle_cmp = 1'b1;
        @(negedge clk); saw_save = 1'b0;
        idle_3d = 1'b1;
        wait_st("R3 into CG", ST_CG, 5);
        repeat (5) @(negedge clk);
        bus_wake = 1'b1;
        @(negedge clk);
        check("R3 bus wake cancel", {27'd0, cg_en, status[3:0]}, {27'd0, 1'b0, ST_ON});
        bus_wake = 1'b0; idle_3d = 1'b0;
        @(negedge clk);
        check("R3 no save on bus cancel", {31'd0, saw_save}, 32'd0);
        // R3 cancel by 3D activity
        idle_3d = 1'b1;
        wait_st("R3 into CG again", ST_CG, 5);
        repeat (3) @(negedge clk);
        idle_3d = 1'b0;
        @(negedge clk);
        check("R3 activity cancel", {27'd0, cg_en, status[3:0]}, {27'd0, 1'b0, ST_ON});
        check("R3 no save on activity cancel", {31'd0, saw_save}, 32'd0);

        // R6 second-stage compute shutdown, then R7 compute wake
        holdoff = 8'd0; idle_cmp = 1'b0; idle_3d = 1'b1;
        wait_st("R6 gated 3D only", ST_GATED, 40);
        check("R6 compute still on", {30'd0, pwr_en}, 32'd2);
        idle_cmp = 1'b1;
        wait_st("R6 compute ramp", ST_RDN, 5);
        check("R6 ramp_sel compute", {30'd0, ramp_sel}, 32'd2);
        check("R6 compute powered in ramp", {30'd0, pwr_en}, 32'd2);
        wait_st("R6 gated again", ST_GATED, 10);
        check("R6 all off", {30'd0, pwr_en}, 32'd0);
        idle_cmp = 1'b0;
        wait_st("R7 compute wake", ST_PUP, 3);
        idle_3d = 1'b0;
        wait_st("R7 ramp up all", ST_RUP, 10);
        check("R7 ramp_sel all", {30'd0, ramp_sel}, 32'd3);
        wait_st("R7 compute wake done", ST_ON, 10);

        // R8 / R9 stalled acknowledge
        ack_en = 1'b0; idle_cmp = 1'b1; idle_3d = 1'b1;
        wait_st("R8 reach save", ST_SAVE, 10);
        repeat (10) @(negedge clk);
        check("R8 hold in save", {27'd0, save_req, status[3:0]}, {27'd0, 1'b1, ST_SAVE});
        check("R9 no early error", {31'd0, ack_err}, 32'd0);
        repeat (ACK_TIMEOUT + 5) @(negedge clk);
        check("R9 timeout flag", {30'd0, ack_err, status[6]}, 32'd3);
        ack_en = 1'b1;
        wait_st("R9 resumes", ST_GATED, 20);
        check("R9 sticky", {31'd0, ack_err}, 32'd1);
        idle_3d = 1'b0;
        wait_st("R9 wake after error", ST_ON, 20);
        do_reset();
        check("R1 error cleared", {31'd0, ack_err}, 32'd0);

        // R10 wrap
        c0 = status[CNT_W+6:7];
        holdoff = 8'd0; idle_cmp = 1'b0;
        for (int k = 0; k < (1 << CNT_W); k++) begin
            idle_3d = 1'b1;
            wait_st("R10 cycle gate", ST_GATED, 30);
            idle_3d = 1'b0;
            wait_st("R10 cycle wake", ST_ON, 30);
        end
        check("R10 wrap", {24'd0, status[CNT_W+6:7]}, {24'd0, c0});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule